// File: doc/BRIEF.md
# Flash End-of-Write Status Read Path

This block sits between a flash model's array and its read port. While an internal program or erase runs, it replaces the normal read word with a status word. Bit 7 is a polling bit that depends on the operation: for a program it is the inverted bit 7 of the word being written, and for any erase it is 0. Bit 6 changes value on every read access. Every other bit reads 0. When the busy flag drops, reads return array contents again. When the part is idle and in identification mode, reads return a manufacturer code or a device code instead of array contents.

The command sequencer raises `busy` on the cycle after the last write cycle of a command: the fourth write for a program, the sixth for an erase. In that same cycle it presents the operation kind and the word being programmed. The block captures these on the rising edge of `busy` and keeps them for the whole operation. A read is one cycle of `rd_req`. The word it selects appears on `rd_data` after the next clock edge and stays there until the next read.

Top module: `wstat_read_path`

## Requirements
- R1: While reset is held and after its release, `rd_data` is 0 until the first read, and the toggle state is cleared.
- R2: A read with `busy` low and `id_mode` low returns `array_data` of that cycle on `rd_data` after the clock edge.
- R3: A read while a program is busy returns on bit 7 the inverse of bit 7 of the word programmed.
- R4: A read while an erase is busy (`op_erase` = 1) returns 0 on bit 7.
- R5: Bit 6 of successive busy reads alternates. Clock cycles with no read do not advance it.
- R6: During busy reads, every bit other than bits 7 and 6 returns 0.
- R7: The first read of each new operation returns 0 on bit 6, including a read in the very cycle `busy` rises.
- R8: The first read after `busy` falls returns true array data, including its bit 7.
- R9: With `busy` low and `id_mode` high, address 0 returns 16'h00BF, address 1 returns 16'h2782, and any other address returns 0. The whole address is compared.
- R10: When `busy` is high, status has priority over identification mode.
- R11: `op_erase` and `op_word` are sampled in the cycle `busy` rises. Changes to them while busy have no effect on status reads.
- R12: `rd_data` holds its value in every cycle without `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| op_word | input | 16 | Word being programmed |
| id_mode | input | 1 | Identification read mode |
| rd_req | input | 1 | One-cycle read access |
| rd_addr | input | 20 | Word address of the read |
| array_data | input | 16 | Word read from the array |
| rd_data | output | 16 | Registered read word |

## Verification
The assertions assume that `busy` rises only together with a valid `op_erase` and `op_word`. They also assume that `rd_req` is a single-cycle strobe sampled at the clock edge and that `array_data` is valid whenever `rd_req` is high. The bench drives every input at the falling clock edge. It draws random busy episodes with random operation kinds and words, and it scrambles `op_erase` and `op_word` in the middle of an operation, so that the capture rule is exercised against stale context. Random read strobes, ID mode and small addresses are mixed with directed cases: a read in the same cycle `busy` rises, ID reads while busy, and the first read after completion.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
   // Operation context held for the length of one internal write
   typedef struct packed {
      logic erase;     // 1: erase in progress, 0: program
      logic src_bit;   // polled bit of the word being programmed
   } wstat_ctx_t;
endpackage

// File: rtl/wstat_ctx.sv
module wstat_ctx
   import wstat_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       op_erase,
   input  logic       op_src_bit,
   output logic       busy_q,
   output logic       op_start,
   output wstat_ctx_t ctx_eff
);
   wstat_ctx_t ctx_q;
   wstat_ctx_t ctx_live;

   assign ctx_live = '{erase: op_erase, src_bit: op_src_bit};
   assign op_start = busy && !busy_q;
   // in the cycle busy rises, the live inputs are the context
   assign ctx_eff  = busy_q ? ctx_q : ctx_live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ctx_q  <= '0;
      end else begin
         busy_q <= busy;
         if (!busy_q) ctx_q <= ctx_live;
      end
   end

   // R11: context stays frozen while the operation runs
   a_r11_ctx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_q) |=> $stable(ctx_q));
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic op_start,
   input  logic rd_req,
   output logic tog_val
);
   logic tog_q;

   // a new operation always presents 0 on its first read
   assign tog_val = op_start ? 1'b0 : tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                tog_q <= 1'b0;
      else if (busy && rd_req)   tog_q <= ~tog_val;
      else if (op_start)         tog_q <= 1'b0;
   end

   // R5: no read, no advance
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy || (!rd_req && !op_start)) |=> $stable(tog_q));
   // R7: a started operation without a read leaves toggle cleared
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !rd_req) |=> (tog_q == 1'b0));
endmodule

// File: rtl/wstat_idsel.sv
module wstat_idsel #(
   parameter int              DATA_W = 16,
   parameter int              ADDR_W = 20,
   parameter bit              ID_EN  = 1'b1,
   parameter logic [DATA_W-1:0] MFR_CODE = 16'h00BF,
   parameter logic [DATA_W-1:0] DEV_CODE = 16'h2782
) (
   input  logic              id_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] idle_data
);
   localparam logic [ADDR_W-1:0] MFR_ADDR = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] DEV_ADDR = ADDR_W'(1);

   generate
      if (ID_EN) begin : g_id
         logic [DATA_W-1:0] id_word;
         always_comb begin
            if (rd_addr == MFR_ADDR)      id_word = MFR_CODE;
            else if (rd_addr == DEV_ADDR) id_word = DEV_CODE;
            else                          id_word = '0;
         end
         assign idle_data = id_mode ? id_word : array_data;
      end else begin : g_no_id
         logic unused_id;
         assign unused_id = id_mode ^ (^rd_addr);
         assign idle_data = array_data;
      end
   endgenerate
endmodule

// File: rtl/wstat_read_path.sv
module wstat_read_path
   import wstat_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter int              ADDR_W   = 20,
   parameter int              POLL_BIT = 7,
   parameter int              TOG_BIT  = 6,
   parameter bit              ID_EN    = 1'b1,
   parameter logic [DATA_W-1:0] MFR_CODE = 16'h00BF,
   parameter logic [DATA_W-1:0] DEV_CODE = 16'h2782
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              op_erase,
   input  logic [DATA_W-1:0] op_word,
   input  logic              id_mode,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [DATA_W-1:0] STAT_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);

   generate
      if (POLL_BIT >= DATA_W || TOG_BIT >= DATA_W || POLL_BIT == TOG_BIT
          || POLL_BIT < 0 || TOG_BIT < 0) begin : g_bad_bits
         $error("status bit positions invalid for data width");
      end
      if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_width
         $error("data or address width too small");
      end
   endgenerate

   logic              busy_q;
   logic              op_start;
   wstat_ctx_t        ctx_eff;
   logic              tog_val;
   logic [DATA_W-1:0] idle_data;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] next_word;

   wstat_ctx u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .op_erase   (op_erase),
      .op_src_bit (op_word[POLL_BIT]),
      .busy_q     (busy_q),
      .op_start   (op_start),
      .ctx_eff    (ctx_eff)
   );

   wstat_toggle u_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .op_start (op_start),
      .rd_req   (rd_req),
      .tog_val  (tog_val)
   );

   wstat_idsel #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .ID_EN    (ID_EN),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_id (
      .id_mode    (id_mode),
      .rd_addr    (rd_addr),
      .array_data (array_data),
      .idle_data  (idle_data)
   );

   // status word assembled bit by bit
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_stat
         if (b == POLL_BIT) begin : g_poll
            assign stat_word[b] = ctx_eff.erase ? 1'b0 : ~ctx_eff.src_bit;
         end else if (b == TOG_BIT) begin : g_tog
            assign stat_word[b] = tog_val;
         end else begin : g_zero
            assign stat_word[b] = 1'b0;
         end
      end
   endgenerate

   assign next_word = busy ? stat_word : idle_data;

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_req) rd_data <= next_word;
   end

   // R12: output holds between reads
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));
   // R2: idle normal reads pass array data
   a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !busy && !id_mode) |=> (rd_data == $past(array_data)));
   // R4: erase polls low
   a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && busy && ctx_eff.erase) |=> (rd_data[POLL_BIT] == 1'b0));
   // R3: program polls inverted source bit
   a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && busy && !ctx_eff.erase) |=>
         (rd_data[POLL_BIT] == !$past(ctx_eff.src_bit)));
   // R6: non-status bits are clear while busy
   a_r6_zero_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && busy) |=> ((rd_data & ~STAT_MASK) == '0));
endmodule

// File: tb/wstat_read_path_tb.sv
module wstat_read_path_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy = 1'b0;
   logic        op_erase = 1'b0;
   logic [15:0] op_word = '0;
   logic        id_mode = 1'b0;
   logic        rd_req = 1'b0;
   logic [19:0] rd_addr = '0;
   logic [15:0] array_data = '0;
   logic [15:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench reference state
   logic m_bq = 1'b0, m_er = 1'b0, m_b7 = 1'b0, m_tog = 1'b0;
   logic [15:0] m_rd = '0;

   always #10 clk = ~clk;

   wstat_read_path u_dut (
      .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
      .op_word(op_word), .id_mode(id_mode), .rd_req(rd_req),
      .rd_addr(rd_addr), .array_data(array_data), .rd_data(rd_data)
   );

   task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   function automatic logic [15:0] id_word(input logic [19:0] a);
      if (a == 20'd0)      return 16'h00BF;
      else if (a == 20'd1) return 16'h2782;
      else                 return 16'h0000;
   endfunction

   // one clock: inputs set at the falling edge, result sampled at the next
   task automatic step(input logic b, input logic e, input logic [15:0] w,
                       input logic id, input logic rq, input logic [19:0] a,
                       input logic [15:0] arr, input string tag);
      logic start, eer, eb7, tv;
      logic [15:0] exp;
      busy = b; op_erase = e; op_word = w; id_mode = id;
      rd_req = rq; rd_addr = a; array_data = arr;
      start = b && !m_bq;
      eer = m_bq ? m_er : e;
      eb7 = m_bq ? m_b7 : w[7];
      tv  = start ? 1'b0 : m_tog;
      exp = m_rd;
      if (rq) begin
         if (b)       exp = {8'h00, (eer ? 1'b0 : ~eb7), tv, 6'h00};
         else if (id) exp = id_word(a);
         else         exp = arr;
      end
      if (b && rq)    m_tog = ~tv;
      else if (start) m_tog = 1'b0;
      if (!m_bq) begin m_er = e; m_b7 = w[7]; end
      m_bq = b;
      m_rd = exp;
      @(negedge clk);
      if (rq && b) begin
         chk((tag != "") ? tag : (eer ? "R4" : "R3"), {15'd0, rd_data[7]}, {15'd0, exp[7]});
         chk(start ? "R7" : "R5", {15'd0, rd_data[6]}, {15'd0, exp[6]});
         chk("R6", rd_data & 16'hFF3F, 16'h0000);
      end else if (rq) begin
         chk((tag != "") ? tag : (id ? "R9" : "R2"), rd_data, exp);
      end else begin
         chk("R12", rd_data, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", rd_data, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", rd_data, 16'h0000);
      // directed cases
      step(0, 0, 16'h0000, 0, 1, 20'd5, 16'h1234, "R2");
      step(1, 0, 16'h0080, 0, 1, 20'd5, 16'hFFFF, "R3");   // R7 same-cycle read
      step(1, 1, 16'h0000, 0, 1, 20'd5, 16'hFFFF, "R11");  // inputs scrambled
      step(1, 1, 16'h0000, 0, 0, 20'd5, 16'hFFFF, "");      // R12 hold
      step(1, 0, 16'h0000, 1, 1, 20'd0, 16'hFFFF, "R10");  // ID while busy
      step(1, 0, 16'h0000, 1, 1, 20'd1, 16'hFFFF, "R10");
      step(0, 0, 16'h0000, 0, 1, 20'd9, 16'h00FF, "R8");
      step(0, 1, 16'h0000, 0, 0, 20'd9, 16'h0000, "");
      step(1, 1, 16'h0000, 0, 1, 20'd9, 16'hFFFF, "R4");   // R7 restart
      step(1, 0, 16'hFFFF, 0, 1, 20'd9, 16'hFFFF, "R4");
      step(0, 0, 16'h0000, 0, 1, 20'd9, 16'h80FF, "R8");
      step(0, 0, 16'h0000, 1, 1, 20'd0, 16'hAAAA, "R9");
      step(0, 0, 16'h0000, 1, 1, 20'd1, 16'hAAAA, "R9");
      step(0, 0, 16'h0000, 1, 1, 20'd2, 16'hAAAA, "R9");
      step(0, 0, 16'h0000, 1, 1, 20'h10000, 16'hAAAA, "R9");
      // program without a read at start, then reads
      step(1, 0, 16'h0000, 0, 0, 20'd3, 16'h0000, "");
      step(1, 0, 16'h0000, 0, 1, 20'd3, 16'h0000, "R3");
      step(1, 0, 16'h0000, 0, 1, 20'd3, 16'h0000, "R3");
      step(0, 0, 16'h0000, 0, 0, 20'd3, 16'h0000, "");
      // constrained random episodes
      for (int i = 0; i < 3000; i++) begin
         logic b;
         b = ($urandom % 8 == 0) ? ~busy : busy;
         step(b, 1'($urandom), 16'($urandom), ($urandom % 4 == 0),
              ($urandom % 2 == 0), 20'($urandom % 4), 16'($urandom), "");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule